// File: doc/BRIEF.md
# Iterative Multiply and Wide Multiply-Accumulate Unit

This unit multiplies two 32-bit operands over several clock cycles and returns either a 32-bit truncated result or a full 64-bit result. The 64-bit result is split into a low word and a high word, which go to two separate destinations. A 3-bit opcode selects the variant. The variants are a plain truncated multiply, a truncated multiply with a 32-bit addend, an unsigned wide multiply, a signed wide multiply, and an unsigned wide multiply that adds a 64-bit accumulator. The accumulator is built from a high operand word and a low operand word.

The caller pulses `start_i` together with the opcode and the operands while the unit is idle. The unit captures everything on that edge. It then runs a shift-and-add loop that handles one multiplier bit per cycle, fixes the sign, and adds the accumulator. At the end it raises `done_o` for one cycle, together with write strobes that say which destination words are valid. Opcodes that have no variant are rejected at once through `undef_o`, and the unit does not start.

Top module: `mul_long_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `res_lo_o` and `res_hi_o` read 0 and `done_o`, `undef_o`, `wr_lo_o` and `wr_hi_o` are low.
- R2: Opcode 3'h0 places bits [31:0] of the product of the two operands in `res_lo_o` and raises `wr_lo_o` only. `res_hi_o` keeps its previous value.
- R3: Opcode 3'h1 places bits [31:0] of (a*b + acc_lo) in `res_lo_o` and raises `wr_lo_o` only. The sum wraps modulo 2^32.
- R4: Opcode 3'h4 forms the unsigned 64-bit product. Bits [31:0] go to `res_lo_o` and bits [63:32] go to `res_hi_o`.
- R5: Opcode 3'h6 sign-extends both operands and forms their 64-bit two's-complement product, split across the two outputs in the same way. This includes the case of the most negative operand.
- R6: Opcode 3'h7 adds the unsigned 64-bit product to {acc_hi, acc_lo} modulo 2^64 and splits the sum across the two outputs in the same way.
- R7: An idle start with opcode 3'h2, 3'h3 or 3'h5 raises `undef_o` for one cycle, on the cycle after the start edge. It raises no `done_o` and no write strobe, leaves both result words unchanged, and leaves the unit idle.
- R8: `done_o` rises exactly W+1 clock edges after the accepted start edge (33 for W=32) and stays high for one cycle.
- R9: A start pulse while an operation is running is ignored. The running operation finishes on time and with its original result.
- R10: The result outputs change only on a cycle in which `done_o` is high.
- R11: Write strobes appear only with `done_o`. Opcodes 3'h4, 3'h6 and 3'h7 raise `wr_lo_o` and `wr_hi_o` together. `wr_hi_o` never appears without `wr_lo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| opcode_i | input | 3 | Operation select |
| op_a_i | input | 32 | First multiplicand |
| op_b_i | input | 32 | Second multiplicand |
| acc_lo_i | input | 32 | Low accumulator word (32-bit addend for opcode 1) |
| acc_hi_i | input | 32 | High accumulator word |
| res_lo_o | output | 32 | Low result word |
| res_hi_o | output | 32 | High result word |
| wr_lo_o | output | 1 | Low destination write strobe |
| wr_hi_o | output | 1 | High destination write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | One-cycle pulse for an unimplemented opcode |

## Verification
The hardest situation to reach from the ports is a second start request that arrives in the middle of a run. It must leave no trace, neither in the result nor in the completion time. The stimulus raises `start_i` with a different opcode and different operands several cycles into a wide signed multiply. It then checks that the result and the latency match the first request only. The signed corner cases need operands chosen deliberately: the most negative value times itself, times the most positive value, and times zero. These show whether the sign correction that follows the unsigned loop is exact.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
  typedef enum logic [2:0] {
    OPC_MUL_LO  = 3'h0,
    OPC_MAC_LO  = 3'h1,
    OPC_MUL_U64 = 3'h4,
    OPC_MUL_S64 = 3'h6,
    OPC_MAC_U64 = 3'h7
  } opc_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LOW  = 2'd1,
    ACC_WIDE = 2'd2
  } acc_e;
endpackage

// File: rtl/mlu_decode.sv
module mlu_decode
  import mlu_pkg::*;
(
  input  logic [2:0] opc_i,
  output logic       valid_o,
  output logic       wide_o,
  output logic       signed_o,
  output acc_e       acc_o
);
  always_comb begin
    valid_o  = 1'b1;
    wide_o   = 1'b0;
    signed_o = 1'b0;
    acc_o    = ACC_NONE;
    case (opc_i)
      OPC_MUL_LO:  ;
      OPC_MAC_LO:  acc_o = ACC_LOW;
      OPC_MUL_U64: wide_o = 1'b1;
      OPC_MUL_S64: begin wide_o = 1'b1; signed_o = 1'b1; end
      OPC_MAC_U64: begin wide_o = 1'b1; acc_o = ACC_WIDE; end
      default:     valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mlu_shift_add.sv
module mlu_shift_add #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o,
  output logic           fin_o
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic [PW-1:0] mcand_q, acc_q;
  logic [W-1:0]  mplier_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        mcand_q  <= {{W{1'b0}}, a_i};
        mplier_q <= b_i;
        acc_q    <= '0;
        cnt_q    <= '0;
        run_q    <= 1'b1;
      end else if (run_q) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign prod_o = acc_q;
  assign fin_o  = fin_q;
endmodule

// File: rtl/mlu_finish.sv
module mlu_finish
  import mlu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] mag_i,
  input  logic           neg_i,
  input  acc_e           acc_i,
  input  logic [W-1:0]   acc_lo_i,
  input  logic [W-1:0]   acc_hi_i,
  output logic [2*W-1:0] sum_o
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod;

  always_comb begin
    prod = neg_i ? (~mag_i + 1'b1) : mag_i;
    case (acc_i)
      ACC_LOW:  sum_o = prod + {{W{1'b0}}, acc_lo_i};
      ACC_WIDE: sum_o = prod + {acc_hi_i, acc_lo_i};
      default:  sum_o = prod;
    endcase
  end
endmodule

// File: rtl/mul_long_unit.sv
module mul_long_unit
  import mlu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [2:0]   opcode_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [W-1:0] acc_lo_i,
  input  logic [W-1:0] acc_hi_i,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic         wr_lo_o,
  output logic         wr_hi_o,
  output logic         done_o,
  output logic         undef_o
);
  localparam int PW = 2 * W;

  logic dec_valid, dec_wide, dec_signed;
  acc_e dec_acc;

  mlu_decode dec_i (
    .opc_i    (opcode_i),
    .valid_o  (dec_valid),
    .wide_o   (dec_wide),
    .signed_o (dec_signed),
    .acc_o    (dec_acc)
  );

  logic         busy_q, wide_q, neg_q;
  acc_e         acc_q;
  logic [W-1:0] acc_lo_q, acc_hi_q;
  logic         accept, load;
  logic [W-1:0] mag_a, mag_b;
  logic [PW-1:0] prod_mag, sum;
  logic         fin;

  assign accept = start_i && !busy_q;
  assign load   = accept && dec_valid;
  assign mag_a  = (dec_signed && op_a_i[W-1]) ? (~op_a_i + 1'b1) : op_a_i;
  assign mag_b  = (dec_signed && op_b_i[W-1]) ? (~op_b_i + 1'b1) : op_b_i;

  mlu_shift_add #(.W(W)) core_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .a_i    (mag_a),
    .b_i    (mag_b),
    .prod_o (prod_mag),
    .fin_o  (fin)
  );

  mlu_finish #(.W(W)) fin_i (
    .mag_i    (prod_mag),
    .neg_i    (neg_q),
    .acc_i    (acc_q),
    .acc_lo_i (acc_lo_q),
    .acc_hi_i (acc_hi_q),
    .sum_o    (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      wide_q   <= 1'b0;
      neg_q    <= 1'b0;
      acc_q    <= ACC_NONE;
      acc_lo_q <= '0;
      acc_hi_q <= '0;
      res_lo_o <= '0;
      res_hi_o <= '0;
      wr_lo_o  <= 1'b0;
      wr_hi_o  <= 1'b0;
      done_o   <= 1'b0;
      undef_o  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      wr_lo_o <= 1'b0;
      wr_hi_o <= 1'b0;
      undef_o <= 1'b0;
      if (accept) begin
        if (dec_valid) begin
          busy_q   <= 1'b1;
          wide_q   <= dec_wide;
          neg_q    <= dec_signed && (op_a_i[W-1] ^ op_b_i[W-1]);
          acc_q    <= dec_acc;
          acc_lo_q <= acc_lo_i;
          acc_hi_q <= acc_hi_i;
        end else begin
          undef_o <= 1'b1;
        end
      end
      if (fin) begin
        busy_q   <= 1'b0;
        done_o   <= 1'b1;
        wr_lo_o  <= 1'b1;
        res_lo_o <= sum[W-1:0];
        if (wide_q) begin
          wr_hi_o  <= 1'b1;
          res_hi_o <= sum[PW-1:W];
        end
      end
    end
  end
endmodule

// File: rtl/mlu_checker.sv
module mlu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] res_lo_o,
  input logic [W-1:0] res_hi_o,
  input logic         wr_lo_o,
  input logic         wr_hi_o,
  input logic         done_o,
  input logic         undef_o
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_hi_with_lo_R11: assert property (@(posedge clk) disable iff (rst)
    wr_hi_o |-> (wr_lo_o && done_o));

  assert_wr_on_done_R11: assert property (@(posedge clk) disable iff (rst)
    wr_lo_o |-> done_o);

  assert_hold_results_R10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(res_lo_o) && $stable(res_hi_o)));

  assert_undef_no_done_R7: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> (!done_o && !wr_lo_o && !wr_hi_o));
endmodule

bind mul_long_unit mlu_checker #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .res_lo_o (res_lo_o),
  .res_hi_o (res_hi_o),
  .wr_lo_o  (wr_lo_o),
  .wr_hi_o  (wr_hi_o),
  .done_o   (done_o),
  .undef_o  (undef_o)
);

// File: tb/mul_long_unit_tb.sv
module mul_long_unit_tb_top;
  localparam int W = 32;
  localparam int NV = 12;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a, b, lo, hi;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    {3'h0, 32'd7,          32'd6,          32'h0,        32'h0},
    {3'h0, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'h0,        32'h0},
    {3'h1, 32'd3,          32'd5,          32'hFFFFFFFF, 32'h0},
    {3'h1, 32'h10000,      32'h10000,      32'd9,        32'hAAAA},
    {3'h4, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'h0,        32'h0},
    {3'h4, 32'h12345678,   32'h9ABCDEF0,   32'h0,        32'h0},
    {3'h6, 32'hFFFFFFFF,   32'd2,          32'h0,        32'h0},
    {3'h6, 32'h80000000,   32'h80000000,   32'h0,        32'h0},
    {3'h6, 32'h80000000,   32'h7FFFFFFF,   32'h0,        32'h0},
    {3'h6, 32'h0,          32'hFFFFFFF0,   32'h0,        32'h0},
    {3'h7, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'hFFFFFFFF, 32'hFFFFFFFF},
    {3'h7, 32'd0,          32'h55555555,   32'h89ABCDEF, 32'h01234567}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  opc = '0;
  logic [31:0] a = '0, b = '0, alo = '0, ahi = '0;
  logic [31:0] res_lo, res_hi;
  logic        wr_lo, wr_hi, done, undef;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_lo = '0, exp_hi = '0;

  always #5 clk = ~clk;

  mul_long_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .opcode_i(opc),
    .op_a_i(a), .op_b_i(b), .acc_lo_i(alo), .acc_hi_i(ahi),
    .res_lo_o(res_lo), .res_hi_o(res_hi), .wr_lo_o(wr_lo), .wr_hi_o(wr_hi),
    .done_o(done), .undef_o(undef)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input vec_t v, input logic [31:0] prev_hi);
    logic [63:0] p;
    case (v.op)
      3'h0: begin p = {32'h0, v.a} * {32'h0, v.b}; return {prev_hi, p[31:0]}; end
      3'h1: begin p = {32'h0, v.a} * {32'h0, v.b} + {32'h0, v.lo};
                  return {prev_hi, p[31:0]}; end
      3'h4: return {32'h0, v.a} * {32'h0, v.b};
      3'h6: return 64'($signed({{32{v.a[31]}}, v.a}) * $signed({{32{v.b[31]}}, v.b}));
      default: return {32'h0, v.a} * {32'h0, v.b} + {v.hi, v.lo};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'h0: return "R2";
      3'h1: return "R3";
      3'h4: return "R4";
      3'h6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    opc = v.op; a = v.a; b = v.b; alo = v.lo; ahi = v.hi; start = 1'b1;
  endtask

  // waits from just after the start edge; returns cycles until done seen
  task automatic wait_done(output int cyc, input vec_t intr, input logic do_intr);
    cyc = 0;
    do begin
      @(posedge clk); @(negedge clk); cyc++;
      if (do_intr && cyc == 5) drive(intr);
      else start = 1'b0;
    end while (!done && cyc < 200);
  endtask

  task automatic run_vec(input vec_t v, input logic do_intr, input vec_t intr);
    int cyc;
    logic [63:0] e;
    string t;
    t = tag_of(v.op);
    e = model(v, exp_hi);
    @(negedge clk); drive(v);
    @(posedge clk); @(negedge clk); start = 1'b0;
    wait_done(cyc, intr, do_intr);
    start = 1'b0;
    check(cyc == W + 1, "R8 latency", 64'(cyc), 64'(W + 1));
    check({res_hi, res_lo} == e, t, {res_hi, res_lo}, e);
    if (v.op[2]) check(wr_lo && wr_hi, "R11 both strobes", {wr_hi, wr_lo}, 2'b11);
    else         check(wr_lo && !wr_hi, "R11 low strobe only", {wr_hi, wr_lo}, 2'b01);
    exp_lo = e[31:0]; exp_hi = e[63:32];
    @(posedge clk); @(negedge clk);
    check(!done && !wr_lo && !wr_hi, "R8 single-cycle done", {done, wr_lo, wr_hi}, 0);
    check({res_hi, res_lo} == e, "R10 hold", {res_hi, res_lo}, e);
  endtask

  task automatic run_undef(input logic [2:0] op);
    @(negedge clk); drive('{op: op, a: 32'h1234, b: 32'h5678, lo: 32'h1, hi: 32'h2});
    @(posedge clk); @(negedge clk); start = 1'b0;
    check(undef == 1'b1, "R7 undef pulse", undef, 1);
    check(!done && !wr_lo && !wr_hi, "R7 no write", {done, wr_lo, wr_hi}, 0);
    check({res_hi, res_lo} == {exp_hi, exp_lo}, "R7 results kept",
          {res_hi, res_lo}, {exp_hi, exp_lo});
    @(posedge clk); @(negedge clk);
    check(undef == 1'b0, "R7 undef one cycle", undef, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({res_hi, res_lo} == 64'h0 && !done && !undef && !wr_lo && !wr_hi,
          "R1 reset state", {res_hi, res_lo}, 64'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check({res_hi, res_lo} == 64'h0 && !done && !undef,
          "R1 after reset", {res_hi, res_lo}, 64'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0, VECS[0]);

    // R9: a start during a signed wide multiply must be ignored
    run_vec(VECS[8], 1'b1, VECS[4]);

    // R7: unimplemented opcodes, then the unit must still accept work
    run_undef(3'h2);
    run_undef(3'h3);
    run_undef(3'h5);
    run_vec(VECS[5], 1'b0, VECS[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule